// File: doc/BRIEF.md
# Double-Buffered Byte-to-Serial Port

This block lets a host processor write bytes over an 8-bit parallel port and sends them out one bit at a time on a single data line. The block makes its own serial clock by dividing the system clock. Three chip selects and a write strobe gate the parallel side. A `busy` output tells the host when it may write the next byte.

Inside there are two storage levels. A holding register takes each written byte. A shift register drives the serial line. The host can therefore write the next byte while the current one is still being sent. `busy` is raised after every accepted write and drops once the holding register has passed its byte to the shifter. How long it stays high depends on how full the two levels are and on the phase of the serial clock. If the host writes while `busy` is high, the byte is dropped and a sticky `overrun` flag is set.

All host inputs pass through two synchroniser flip-flops into the system clock domain. A write is detected at the strobe's deasserting edge.

Top module: `cfg_serial_port`

## Requirements
- R1: A write takes effect only if, in the last synchronised cycle before `host_wr_n` rises, `host_cs0_n`=0, `host_cs1_n`=0, `host_cs2`=1 and `host_wr_n`=0 all hold together. Any other write leaves `busy` at 0 and leaves `overrun` unchanged.
- R2: The byte stored is the value of `host_d` while the strobe was still low. `host_d` may change in the same cycle that `host_wr_n` rises.
- R3: On an accepted write, `busy` rises at the third rising `clk` edge after `host_wr_n` goes high, and not before.
- R4: Each byte appears on `ser_dout` most significant bit first. Each bit lasts one full `ser_clk` period. `ser_dout` changes only at the `clk` edge where `ser_clk` goes from 1 to 0.
- R5: The held byte moves to the shifter at the first falling edge of `ser_clk` at which the shifter is idle or has just finished its eighth bit. `busy` drops at that same edge, so queued bytes follow each other with no gap.
- R6: `busy` stays high for at least 1 and at most 18*HALF_DIV `clk` cycles, which is nine serial clock periods.
- R7: A write that arrives while `busy` is high is dropped. It sets `overrun` to 1, and `overrun` stays at 1 until reset.
- R8: After reset, `busy`=0, `overrun`=0, `ser_dout`=1 and `ser_clk`=0.
- R9: `ser_dout` is 1 whenever no byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cs0_n | input | 1 | Chip select, active low |
| host_cs1_n | input | 1 | Chip select, active low |
| host_cs2 | input | 1 | Chip select, active high |
| host_wr_n | input | 1 | Write strobe, active low; data taken at its rising edge |
| host_d | input | 8 | Parallel write data |
| busy | output | 1 | 1 while the holding register is full |
| overrun | output | 1 | Sticky flag: a write was dropped because the port was busy |
| ser_clk | output | 1 | Divided serial clock |
| ser_dout | output | 1 | Serial data, MSB first, idle high |

## Verification
Two events can land on the same `clk` edge: a write being accepted into the holding register, and a serial falling edge that decides whether the held byte moves to the shifter. Random gaps between writes and the free-running divider sweep the strobe release across every phase of `ser_clk`. Some writes therefore land exactly where the shifter finishes its eighth bit or is idle. The bench runs a port-level model that advances only on observed falling edges of `ser_clk`, using the `busy` value from before that edge. It compares every `ser_dout` sample with the model and checks that `busy` drops only on a transfer edge.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              sel0_n;
    logic              sel1_n;
    logic              sel2;
    logic              wr_n;
    logic [BYTE_W-1:0] data;
  } host_bus_t;

  localparam host_bus_t BUS_IDLE = '{sel0_n: 1'b1, sel1_n: 1'b1, sel2: 1'b0,
                                     wr_n: 1'b1, data: '0};
endpackage

// File: rtl/cfg_host_sync.sv
module cfg_host_sync
  import cfg_ser_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  host_bus_t         bus_i,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  host_bus_t pipe_q [DEPTH];
  host_bus_t newest, oldest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= BUS_IDLE;
    end else begin
      pipe_q[0] <= bus_i;
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  always_comb begin
    newest  = pipe_q[SYNC_STAGES-1];
    oldest  = pipe_q[SYNC_STAGES];
    wr_stb  = newest.wr_n && !oldest.wr_n &&
              !oldest.sel0_n && !oldest.sel1_n && oldest.sel2;
    wr_data = oldest.data;
  end

  // R3: the deasserting edge yields a single-cycle strobe
  a_r3_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/cfg_sclk_gen.sv
module cfg_sclk_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic fall_tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d, wrap;

  always_comb begin
    wrap      = (cnt_q == CW'(HALF_DIV - 1));
    cnt_d     = wrap ? '0 : cnt_q + CW'(1);
    sclk_d    = wrap ? ~sclk_q : sclk_q;
    fall_tick = wrap && sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

  // R4: a fall tick is followed by a low serial clock
  a_r4_tick_then_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |=> !sclk);
endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter
  import cfg_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              fall_tick,
  output logic              busy,
  output logic              overrun,
  output logic              sdo
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] hold_q, hold_d, sh_q, sh_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              full_q, full_d, ovr_q, ovr_d;

  always_comb begin
    hold_d = hold_q;
    sh_d   = sh_q;
    left_d = left_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    if (fall_tick) begin
      if (left_q > CNT_W'(1)) begin
        sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
        left_d = left_q - CNT_W'(1);
      end else if (full_q) begin
        sh_d   = hold_q;
        left_d = CNT_W'(BYTE_W);
        full_d = 1'b0;
      end else begin
        left_d = '0;
      end
    end
    if (wr_stb) begin
      if (full_q) begin
        ovr_d = 1'b1;
      end else begin
        hold_d = wr_data;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      left_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      left_q <= left_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign busy    = full_q;
  assign overrun = ovr_q;
  assign sdo     = (left_q != '0) ? sh_q[BYTE_W-1] : 1'b1;

  // R7: overrun is sticky
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R7: a write while busy leaves the held byte untouched
  a_r7_drop_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && full_q) |=> $stable(hold_q));
  // R4: serial data moves only on a serial falling edge
  a_r4_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_tick |=> $stable(sdo));
  // R3: an accepted write raises busy on the next edge
  a_r3_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !full_q) |=> busy);
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_ser_pkg::*;
#(
  parameter int unsigned HALF_DIV    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs0_n,
  input  logic              host_cs1_n,
  input  logic              host_cs2,
  input  logic              host_wr_n,
  input  logic [BYTE_W-1:0] host_d,
  output logic              busy,
  output logic              overrun,
  output logic              ser_clk,
  output logic              ser_dout
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  host_bus_t         bus;
  logic              wr_stb, fall_tick;
  logic [BYTE_W-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    bus.sel0_n = host_cs0_n;
    bus.sel1_n = host_cs1_n;
    bus.sel2   = host_cs2;
    bus.wr_n   = host_wr_n;
    bus.data   = host_d;
  end

  cfg_host_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .bus_i(bus),
    .wr_stb(wr_stb), .wr_data(wr_data));

  cfg_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_int_n), .sclk(ser_clk), .fall_tick(fall_tick));

  cfg_byte_shifter u_shift (
    .clk(clk), .rst_n(rst_int_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .fall_tick(fall_tick), .busy(busy), .overrun(overrun), .sdo(ser_dout));
endmodule

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs0_n, cs1_n, cs2, wr_n;
  logic [7:0] d;
  logic       busy, overrun, ser_clk, ser_dout;

  int  n_cmp = 0;
  int  n_mis = 0;
  bit  done = 0;
  bit  mon_on = 0;

  logic [7:0] pend_byte;
  logic [7:0] mq[$];
  logic [7:0] m_sh;
  int         m_left;
  logic       prev_sclk, prev_busy;
  int         bcnt;

  always #4 clk = ~clk;

  cfg_serial_port #(.HALF_DIV(HALF)) i_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .host_cs0_n(cs0_n), .host_cs1_n(cs1_n),
    .host_cs2(cs2), .host_wr_n(wr_n), .host_d(d), .busy(busy),
    .overrun(overrun), .ser_clk(ser_clk), .ser_dout(ser_dout));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_sdo(input int left, input logic [7:0] sh);
    return (left != 0) ? sh[7] : 1'b1;
  endfunction

  function automatic bit sel_ok(input bit c0n, input bit c1n, input bit c2);
    return !c0n && !c1n && c2;
  endfunction

  // port-level model, advanced on observed ser_clk falling edges
  always @(negedge clk) begin
    if (mon_on) begin
      bit fell, load_now;
      fell = prev_sclk && !ser_clk;
      load_now = 0;
      if (!prev_busy && busy) begin
        mq.push_back(pend_byte);
        bcnt = 0;
      end
      if (busy) bcnt++;
      if (fell) begin
        if (m_left > 1) begin
          m_sh = m_sh << 1;
          m_left--;
        end else if (prev_busy) begin
          m_sh = (mq.size() > 0) ? mq.pop_front() : 8'hxx;
          m_left = 8;
          load_now = 1;
        end else begin
          m_left = 0;
        end
      end
      chk(ser_dout === exp_sdo(m_left, m_sh), "R2 R4 R9 serial bit", ser_dout,
          exp_sdo(m_left, m_sh));
      if (fell || ser_dout !== prev_sclk) begin end
      if (prev_busy && !busy) begin
        chk(load_now, "R5 busy release on transfer edge", load_now, 1);
        chk(bcnt >= 1 && bcnt <= 18 * HALF, "R6 busy length", bcnt, 18 * HALF);
      end
      if (load_now) chk(busy == 1'b0, "R5 busy low after transfer", busy, 0);
      prev_sclk = ser_clk;
      prev_busy = busy;
    end
  end

  task automatic idle_bus();
    cs0_n = 1'b1; cs1_n = 1'b1; cs2 = 1'b0; wr_n = 1'b1;
  endtask

  task automatic host_write(input logic [7:0] val, input bit c0n, input bit c1n,
                            input bit c2, input int len);
    @(negedge clk);
    cs0_n = c0n; cs1_n = c1n; cs2 = c2; wr_n = 1'b0; d = val;
    repeat (len - 1) @(negedge clk);
    @(negedge clk);
    idle_bus();
    d = ~val;
  endtask

  task automatic wait_ready();
    while (busy) @(negedge clk);
  endtask

  task automatic good_write(input logic [7:0] val, input int len);
    pend_byte = val;
    host_write(val, 1'b0, 1'b0, 1'b1, len);
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R3 busy not yet", busy, 0);
    @(negedge clk);
    chk(busy == 1'b1, "R3 busy raised", busy, 1);
  endtask

  task automatic do_reset();
    mon_on = 0;
    @(negedge clk);
    rst_n = 1'b0;
    idle_bus();
    d = 8'h00;
    #1;
    chk(busy == 1'b0, "R8 reset busy", busy, 0);
    chk(overrun == 1'b0, "R8 reset overrun", overrun, 0);
    chk(ser_dout == 1'b1, "R8 reset ser_dout", ser_dout, 1);
    chk(ser_clk == 1'b0, "R8 reset ser_clk", ser_clk, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mq.delete();
    m_left = 0;
    m_sh = 8'h00;
    bcnt = 0;
    prev_sclk = ser_clk;
    prev_busy = busy;
    mon_on = 1;
  endtask

  task automatic drain();
    wait_ready();
    repeat (24 * HALF) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1997));
    rst_n = 1'b1;
    idle_bus();
    d = 8'h00;
    do_reset();
    repeat (5) @(negedge clk);

    // R2: data changes as the strobe releases; A5 must be sent
    good_write(8'hA5, 2);
    drain();

    // R1: each chip select wrong in turn
    for (int k = 0; k < 3; k++) begin
      host_write(8'h3C, k == 0, k == 1, k != 2, 2);
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R1 bad select no busy", busy, 0);
      chk(overrun == 1'b0, "R1 bad select no overrun", overrun, 0);
    end

    // R5: back-to-back bytes, second waits in the holding register
    good_write(8'hF0, 1);
    wait_ready();
    good_write(8'h0F, 1);

    // R7: write while busy is dropped and flags overrun
    chk(busy == 1'b1, "R7 precondition busy", busy, 1);
    host_write(8'h99, 1'b0, 1'b0, 1'b1, 1);
    repeat (3) @(negedge clk);
    chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
    chk(busy == 1'b1, "R7 busy kept", busy, 1);
    drain();
    chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);

    // random mix
    for (int n = 0; n < 150; n++) begin
      int pick, gap, len;
      wait_ready();
      gap = $urandom_range(0, 4 * HALF + 3);
      repeat (gap) @(negedge clk);
      pick = $urandom_range(0, 9);
      len = $urandom_range(1, 3);
      if (pick == 0) begin
        bit c0n, c1n, c2;
        logic ov;
        ov = overrun;
        do begin
          c0n = 1'($urandom_range(0, 1));
          c1n = 1'($urandom_range(0, 1));
          c2  = 1'($urandom_range(0, 1));
        end while (sel_ok(c0n, c1n, c2));
        host_write(8'($urandom), c0n, c1n, c2, len);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 random bad select", busy, 0);
        chk(overrun == ov, "R1 random overrun unchanged", overrun, ov);
      end else begin
        good_write(8'($urandom), len);
      end
    end
    drain();

    do_reset();
    repeat (4) @(negedge clk);
    chk(overrun == 1'b0, "R7 overrun cleared only by reset", overrun, 0);
    good_write(8'h81, 2);
    drain();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_mis++;
      $display("FAIL watchdog R5 actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end
endmodule